// File: doc/BRIEF.md
# External Bus Read Sequencer

This block runs read cycles on a narrow external parallel memory bus for a small embedded controller. A request carries a 21-bit byte address, a word/byte flag and a flag that picks the I/O zone instead of the memory zone. The sequencer then drives the address, raises the select that matches the target zone, and raises the read strobe. It waits a programmable number of internal wait states and samples the data bus at the end of the data state.

On an 8-bit memory zone with burst reads enabled, a word access picks up its upper byte in a second data state at the next byte address. An optional burst-wait state can come before that second data state. A programmable number of hold states with select and strobe released closes every cycle. The assembled result is then presented with a one-cycle valid pulse.

The memory zone and the I/O zone each have their own configuration inputs. The I/O zone never uses the burst states.

Top module: `ext_rd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `bus_rd`, `bus_zsel`, `bus_iosel` and `rd_valid` are all low.
- R2: A request (`req` high) is accepted only when `busy` is low. The address, the access flags and the configuration of the chosen zone are captured at acceptance. A request made or configuration changed while `busy` is high has no effect on the cycle in progress.
- R3: In the cycle after acceptance (the address state), `busy` and `bus_rd` are high, `bus_addr` equals the requested address, and exactly one select is high: `bus_iosel` when `req_io`=1, `bus_zsel` otherwise.
- R4: Between the address state and the first data state the sequencer inserts exactly WAIT internal wait states. WAIT is the 2-bit `cfg_wait` (memory zone) or `io_wait` (I/O zone), and WAIT=0 means no wait state.
- R5: The bus is sampled once, at the end of the first data state, when any of these holds: the zone is 16-bit (`cfg_wide`/`io_wide`=1), burst is off (`cfg_burst`=0), or the access is a byte (`req_word`=0). The result is the full 16-bit `bus_din` for a word on a 16-bit zone. In every other case it is {8'h00, `bus_din[7:0]`}.
- R6: For a word read on an 8-bit memory zone with `cfg_burst`=1 and `cfg_burst_wait`=0, a second data state follows the first data state directly. In the second data state `bus_addr` = {a[20], a[19:0]+1}. The result is {second-state `bus_din[7:0]`, first-state `bus_din[7:0]`}.
- R7: With `cfg_burst`=1 and `cfg_burst_wait`=1 on the same access, one burst-wait state comes before the second data state. The burst-wait state already drives the next address, so the next address is on the bus for two cycles.
- R8: The I/O zone never takes the burst states, whatever the burst settings, and uses `io_wait`, `io_hold` and `io_wide` in place of the memory-zone inputs.
- R9: After the last data state there are exactly HOLD hold states (`cfg_hold` or `io_hold`, 2 bits each). During these states `busy` stays high while `bus_rd` and both selects are low. HOLD=0 ends the cycle at once.
- R10: `rd_valid` is high for exactly one cycle, the first cycle with `busy` low after a cycle. `rd_data` holds the result at that point, and `rd_valid` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a read cycle (taken when idle) |
| req_io | input | 1 | 1 = I/O zone, 0 = memory zone |
| req_word | input | 1 | 1 = word read, 0 = byte read |
| req_addr | input | 21 | Byte address of the access |
| cfg_wait | input | 2 | Memory zone internal wait count |
| cfg_hold | input | 2 | Memory zone hold count |
| cfg_wide | input | 1 | Memory zone is 16-bit |
| cfg_burst | input | 1 | Memory zone burst read enable |
| cfg_burst_wait | input | 1 | Insert burst-wait state before second data state |
| io_wait | input | 2 | I/O zone internal wait count |
| io_hold | input | 2 | I/O zone hold count |
| io_wide | input | 1 | I/O zone is 16-bit |
| bus_din | input | 16 | External data bus |
| bus_addr | output | 21 | External address bus |
| bus_zsel | output | 1 | Memory zone select |
| bus_iosel | output | 1 | I/O zone select |
| bus_rd | output | 1 | Read strobe |
| busy | output | 1 | Cycle in progress |
| rd_data | output | 16 | Assembled read result |
| rd_valid | output | 1 | One-cycle result strobe |

## Verification
The bench goes after the combinations where the cycle takes a different path. These are the four burst setting patterns crossed with byte and word accesses on 8- and 16-bit zones, and I/O accesses with burst bits set. A design that mixed them up would show the next address on the bus for the wrong number of cycles or put the wrong byte into the upper half of the result. WAIT and HOLD at 0 and at 3 are covered: an off-by-one counter changes the select or hold cycle count by one. While a cycle runs, the bench drives new requests and changes the configuration at random. A design that re-sampled either would change its cycle length or its address mid-cycle.

// File: rtl/ext_rd_seq.sv
module ext_rd_seq #(
  parameter int AW = 21,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_io,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] cfg_wait,
  input  logic [CW-1:0] cfg_hold,
  input  logic          cfg_wide,
  input  logic          cfg_burst,
  input  logic          cfg_burst_wait,
  input  logic [CW-1:0] io_wait,
  input  logic [CW-1:0] io_hold,
  input  logic          io_wide,
  input  logic [15:0]   bus_din,
  output logic [AW-1:0] bus_addr,
  output logic          bus_zsel,
  output logic          bus_iosel,
  output logic          bus_rd,
  output logic          busy,
  output logic [15:0]   rd_data,
  output logic          rd_valid
);
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WAIT, S_DAT1, S_BWAIT, S_DAT2, S_HOLD
  } st_t;

  st_t           st;
  logic [AW-1:0] a_q;
  logic [CW-1:0] cnt, wait_q, hold_q;
  logic          io_q, word_q, wide_q, bst_q, bw_q;
  logic [15:0]   data_q;
  logic          valid_q;

  wire [AW-1:0] nxt_addr = {a_q[AW-1], a_q[AW-2:0] + 1'b1};
  wire          take     = req && (st == S_IDLE);
  wire          sel_wide = req_io ? io_wide : cfg_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      cnt     <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
      io_q    <= 1'b0;
      word_q  <= 1'b0;
      wide_q  <= 1'b0;
      bst_q   <= 1'b0;
      bw_q    <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          st     <= S_ADDR;
          a_q    <= req_addr;
          io_q   <= req_io;
          word_q <= req_word;
          wide_q <= sel_wide;
          wait_q <= req_io ? io_wait : cfg_wait;
          hold_q <= req_io ? io_hold : cfg_hold;
          bst_q  <= !req_io && !sel_wide && req_word && cfg_burst;
          bw_q   <= cfg_burst_wait;
        end
        S_ADDR: begin
          if (wait_q != '0) begin
            st  <= S_WAIT;
            cnt <= wait_q;
          end else begin
            st <= S_DAT1;
          end
        end
        S_WAIT: begin
          if (cnt == CW'(1)) st <= S_DAT1;
          else cnt <= cnt - 1'b1;
        end
        S_DAT1: begin
          data_q[7:0]  <= bus_din[7:0];
          data_q[15:8] <= (wide_q && word_q) ? bus_din[15:8] : 8'h00;
          if (bst_q) begin
            st <= bw_q ? S_BWAIT : S_DAT2;
          end else if (hold_q != '0) begin
            st  <= S_HOLD;
            cnt <= hold_q;
          end else begin
            st      <= S_IDLE;
            valid_q <= 1'b1;
          end
        end
        S_BWAIT: st <= S_DAT2;
        S_DAT2: begin
          data_q[15:8] <= bus_din[7:0];
          if (hold_q != '0) begin
            st  <= S_HOLD;
            cnt <= hold_q;
          end else begin
            st      <= S_IDLE;
            valid_q <= 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == CW'(1)) begin
            st      <= S_IDLE;
            valid_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_rd    = (st != S_IDLE) && (st != S_HOLD);
  assign bus_zsel  = bus_rd && !io_q;
  assign bus_iosel = bus_rd && io_q;
  assign bus_addr  = (st == S_BWAIT || st == S_DAT2) ? nxt_addr : a_q;
  assign busy      = (st != S_IDLE);
  assign rd_data   = data_q;
  assign rd_valid  = valid_q;
endmodule

module ext_rd_seq_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          busy,
  input logic          bus_rd,
  input logic          bus_zsel,
  input logic          bus_iosel,
  input logic [AW-1:0] bus_addr,
  input logic          rd_valid
);
  // R3
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_zsel && bus_iosel));
  // R9
  rd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd == (bus_zsel || bus_iosel));
  // R3
  rd_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> busy);
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && bus_rd));
  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R10
  valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $fell(busy)));
  // R8
  io_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_iosel && $past(bus_iosel)) |-> $stable(bus_addr));
endmodule

bind ext_rd_seq ext_rd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .bus_rd(bus_rd),
  .bus_zsel(bus_zsel), .bus_iosel(bus_iosel), .bus_addr(bus_addr),
  .rd_valid(rd_valid)
);

// File: tb/ext_rd_seq_bench.sv
module ext_rd_seq_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_io = 1'b0, req_word = 1'b0;
  logic [20:0] req_addr = '0;
  logic [1:0]  cfg_wait = '0, cfg_hold = '0, io_wait = '0, io_hold = '0;
  logic        cfg_wide = 1'b0, cfg_burst = 1'b0, cfg_burst_wait = 1'b0, io_wide = 1'b0;
  logic [15:0] bus_din;
  logic [20:0] bus_addr;
  logic        bus_zsel, bus_iosel, bus_rd, busy, rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] din_of(input logic [20:0] a);
    return {a[7:0] + 8'h91, a[7:0] ^ a[15:8] ^ a[20:16] ^ 8'h3C};
  endfunction

  function automatic logic [20:0] nxt_of(input logic [20:0] a);
    return {a[20], a[19:0] + 20'd1};
  endfunction

  assign bus_din = din_of(bus_addr);

  ext_rd_seq u_ext_rd_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_io(req_io), .req_word(req_word),
    .req_addr(req_addr), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
    .cfg_wide(cfg_wide), .cfg_burst(cfg_burst), .cfg_burst_wait(cfg_burst_wait),
    .io_wait(io_wait), .io_hold(io_hold), .io_wide(io_wide), .bus_din(bus_din),
    .bus_addr(bus_addr), .bus_zsel(bus_zsel), .bus_iosel(bus_iosel),
    .bus_rd(bus_rd), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx(input bit io, input bit word, input logic [20:0] a,
                    input logic [1:0] w, input logic [1:0] h, input bit wide,
                    input bit bre, input bit wbr, input bit noise);
    bit burst;
    int n_sel = 0, n_rd = 0, n_hold = 0, n_nxt = 0, n_bad = 0, n_v = 0, guard = 0;
    logic [15:0] exp_d;
    req = 1'b1; req_io = io; req_word = word; req_addr = a;
    if (io) begin
      io_wait = w; io_hold = h; io_wide = wide;
      cfg_wait = ~w; cfg_hold = ~h; cfg_wide = ~wide;
    end else begin
      cfg_wait = w; cfg_hold = h; cfg_wide = wide;
      io_wait = ~w; io_hold = ~h; io_wide = ~wide;
    end
    cfg_burst = bre; cfg_burst_wait = wbr;
    burst = !io && !wide && word && bre;
    if (burst) exp_d = {din_of(nxt_of(a))[7:0], din_of(a)[7:0]};
    else if (word && wide) exp_d = din_of(a);
    else exp_d = {8'h00, din_of(a)[7:0]};
    @(negedge clk);
    // R3: address state right after acceptance
    chk(busy && bus_rd && bus_addr == a && bus_iosel == io && bus_zsel == !io,
        "R3 addr state", {busy, bus_rd, bus_iosel, bus_zsel}, {3'b111, !io});
    while (busy && guard < 40) begin
      guard++;
      if (bus_zsel || bus_iosel) n_sel++;
      if (bus_rd) n_rd++;
      if (!bus_rd) n_hold++;
      if (bus_addr == nxt_of(a)) n_nxt++;
      if (io ? bus_zsel : bus_iosel) n_bad++;
      if (rd_valid) n_v++;
      if (noise) begin
        req = $urandom_range(0, 1); req_io = $urandom_range(0, 1);
        req_word = $urandom_range(0, 1); req_addr = 21'($urandom);
        cfg_wait = 2'($urandom); cfg_hold = 2'($urandom); io_wait = 2'($urandom);
        io_hold = 2'($urandom); cfg_wide = $urandom_range(0, 1); io_wide = $urandom_range(0, 1);
        cfg_burst = $urandom_range(0, 1); cfg_burst_wait = $urandom_range(0, 1);
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
    end
    req = 1'b0;
    // R4 R6 R7: select cycle count covers address, waits, data and burst states
    chk(n_sel == 2 + int'(w) + (burst ? (wbr ? 2 : 1) : 0), "R4 select cycles",
        n_sel, 2 + int'(w) + (burst ? (wbr ? 2 : 1) : 0));
    chk(n_rd == n_sel, "R9 strobe tracks select", n_rd, n_sel);
    // R9
    chk(n_hold == int'(h), "R9 hold cycles", n_hold, int'(h));
    // R6 R7 R8: next address only in burst states
    chk(n_nxt == (burst ? (wbr ? 2 : 1) : 0), "R7 next-address cycles",
        n_nxt, burst ? (wbr ? 2 : 1) : 0);
    chk(n_bad == 0, "R8 wrong select", n_bad, 0);
    // R10
    chk(n_v == 0, "R10 valid during busy", n_v, 0);
    chk(rd_valid == 1'b1, "R10 valid at end", rd_valid, 1);
    // R5 R6 R2
    chk(rd_data == exp_d, burst ? "R6 burst data" : "R5 single data", rd_data, exp_d);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R10 valid one cycle", rd_valid, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !bus_rd && !bus_zsel && !bus_iosel && !rd_valid, "R1 in reset",
        {busy, bus_rd, bus_zsel, bus_iosel, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_rd && !rd_valid, "R1 after reset", {busy, bus_rd, rd_valid}, 0);
    // directed corners
    tx(0, 1, 21'h012345, 2'd0, 2'd0, 0, 1, 0, 0);
    tx(0, 1, 21'h1FFFFF, 2'd3, 2'd3, 0, 1, 1, 0);
    tx(0, 1, 21'h0000FF, 2'd1, 2'd0, 0, 0, 1, 0);
    tx(0, 0, 21'h0ABCDE, 2'd0, 2'd2, 0, 1, 1, 0);
    tx(0, 1, 21'h155555, 2'd2, 2'd1, 1, 1, 1, 0);
    tx(1, 1, 21'h000321, 2'd3, 2'd0, 0, 1, 1, 0);
    tx(1, 1, 21'h000322, 2'd0, 2'd3, 1, 1, 0, 0);
    // R2: noise during busy
    tx(0, 1, 21'h0F0F0F, 2'd1, 2'd1, 0, 1, 1, 1);
    for (int i = 0; i < 300; i++) begin
      tx($urandom_range(0, 3) == 0, $urandom_range(0, 1), 21'($urandom),
         2'($urandom), 2'($urandom), $urandom_range(0, 1), $urandom_range(0, 1),
         $urandom_range(0, 1), $urandom_range(0, 1));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule